// File: doc/BRIEF.md
# Independent-Iteration Loop Sequencer

This block sits in front of an issue stage and steers a counted loop whose iterations do not depend on one another. When idle it accepts a loop-start instruction word and decodes four things from it: the index register, a power-of-two step, the loop's preamble mode, and a set of registers that are to behave as forwarding nodes instead of architectural storage. It then releases iterations one after another. Each released iteration carries its own copy of the index value and a short wrapping tag.

When the loop has no preamble, iterations leave on consecutive cycles. The only things that hold them back are a stall input and a cap on the number of iterations that are in flight. When the loop has a preamble, each iteration's preamble runs serially. An end-of-preamble marker carries a short backward offset, and the sequencer turns it into a redirect target so that the next iteration's preamble can begin. The loop is tested at the bottom, so its body always runs at least once. A done pulse follows the loop-end report of the final iteration. The forwarding-node bitmap is held steady for the whole loop.

Top module: `vloop_seq`

## Requirements
- R1: While reset is high, and after it until the first start, issue_valid, done and redirect_valid are 0, node_map is all zeros and issue_tag is 0.
- R2: start_word field positions are:
  - bits [2:0]: index register number
  - bits [5:3]: step exponent k
  - bits [13:6]: register mask
  - bits [15:14]: group
  - bit 16: file (1 = floating point)
  - bit 17: live-out (1) or live-in (0)
  - bit 18: preamble mode

  node_map bit (file*32 + group*8 + j) is set for each set mask bit j. Bit (index register number) of the integer file is always set. node_live_out shows bit 17. index_reg shows bits [2:0].
- R3: The step is 2^k (1 to 128). Iteration n carries issue_index = n*step and issue_tag = n mod 16.
- R4: The loop is tested at the bottom. It runs floor(trip_limit/step)+1 iterations, so it runs exactly one when trip_limit < step.
- R5: Without a preamble, and with no stall and no cap, issue_valid stays high on consecutive cycles until the last iteration has been released.
- R6: While stall is high no iteration is released. Once stall is released, issue resumes with no index skipped or repeated.
- R7: At most 16 iterations are outstanding, meaning released but not yet retired by a body_end pulse. At 16, issue_valid stays low until a retire.
- R8: In preamble mode one iteration is released and then issue waits for pre_end. If more iterations remain, the cycle after pre_end shows redirect_valid for one cycle with redirect_pc = mark_pc - 4*mark_off, and the next iteration is released in that same cycle. A pre_end that arrives after the last iteration produces no redirect.
- R9: done is a one-cycle pulse. It appears in the cycle after the body_end that retires the last outstanding iteration. The block then returns to idle.
- R10: start_valid is ignored unless the block is idle. node_map and node_live_out are held from decode until the next accepted start.
- R11: The mask contents and the live-in/live-out choice have no effect on issue timing or on completion. A loop with all eight registers marked live-in issues back-to-back and completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Loop-start word present |
| start_word | input | 19 | Loop-start fields |
| trip_limit | input | IDX_W | Highest index allowed to run, inclusive |
| stall | input | 1 | Holds iteration issue |
| pre_end | input | 1 | End-of-preamble marker reached |
| mark_pc | input | PC_W | Address of the end-of-preamble marker |
| mark_off | input | OFF_W | Backward word offset carried by the marker |
| body_end | input | 1 | One iteration reached loop end (retire) |
| issue_valid | output | 1 | An iteration is released this cycle |
| issue_index | output | IDX_W | Index value of the released iteration |
| issue_tag | output | TAG_W | Wrapping iteration tag |
| index_reg | output | 3 | Index register number |
| node_map | output | 64 | Forwarding-node bitmap (int 0..31, fp 32..63) |
| node_live_out | output | 1 | Marked registers are live-out |
| redirect_valid | output | 1 | Fetch redirect to loop start |
| redirect_pc | output | PC_W | Redirect target |
| done | output | 1 | Loop complete pulse |

## Verification
Issue is driven with several step exponents and limits: step 1, step 2, step 8, and step 128 with a zero limit. Together these separate a correct iteration count from an off-by-one at the bottom test and a wrong shift of the step. A run held under stall, and a long run with no retires, tell back-pressure from the in-flight cap apart. The long run also lets the tag wrap past 15. A preamble loop checks that issue really stops between markers, that each redirect target is computed from that marker's own address and offset, and that the last marker is absorbed. Bitmaps are compared after decode for floating-point and integer groups and for all-set masks.

// File: rtl/vloop_pkg.sv
package vloop_pkg;

    localparam int WORD_W     = 19;
    localparam int NODE_W     = 64;
    localparam int BANK_REGS  = 32;
    localparam int GROUP_REGS = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRE   = 2'd1,
        ST_ISSUE = 2'd2,
        ST_DRAIN = 2'd3
    } seq_state_e;

    // Packed from MSB to LSB: the last member sits at bit 0.
    typedef struct packed {
        logic       has_pre;   // [18]
        logic       live_out;  // [17]
        logic       fp_file;   // [16]
        logic [1:0] group;     // [15:14]
        logic [7:0] mask;      // [13:6]
        logic [2:0] step_log;  // [5:3]
        logic [2:0] idx_reg;   // [2:0]
    } loop_cfg_t;

    function automatic loop_cfg_t unpack_word(input logic [WORD_W-1:0] w);
        return loop_cfg_t'(w);
    endfunction

endpackage

// File: rtl/vloop_decode.sv
module vloop_decode
    import vloop_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output loop_cfg_t         cfg,
    output logic [NODE_W-1:0] node_map
);
    assign cfg = unpack_word(word);

    for (genvar b = 0; b < NODE_W; b++) begin : g_node
        localparam int FILE = b / BANK_REGS;
        localparam int GRP  = (b % BANK_REGS) / GROUP_REGS;
        localparam int LANE = b % GROUP_REGS;
        logic masked;
        assign masked = (cfg.fp_file == 1'(FILE)) && (cfg.group == 2'(GRP)) && cfg.mask[LANE];
        if (b < GROUP_REGS) begin : g_idx
            assign node_map[b] = masked || (cfg.idx_reg == 3'(LANE));
        end else begin : g_plain
            assign node_map[b] = masked;
        end
    end
endmodule

// File: rtl/vloop_index.sv
module vloop_index #(
    parameter int IDX_W = 16,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [2:0]       step_log,
    input  logic [IDX_W-1:0] limit,
    input  logic             advance,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag,
    output logic             last
);
    localparam int SUM_W = IDX_W + 1;

    logic [IDX_W-1:0] idx_q, lim_q;
    logic [TAG_W-1:0] tag_q;
    logic [2:0]       k_q;
    logic [SUM_W-1:0] step_w, nxt;

    assign step_w = SUM_W'(1) << k_q;
    assign nxt    = {1'b0, idx_q} + step_w;
    assign last   = nxt > {1'b0, lim_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            lim_q <= '0;
            tag_q <= '0;
            k_q   <= '0;
        end else if (load) begin
            idx_q <= '0;
            tag_q <= '0;
            lim_q <= limit;
            k_q   <= step_log;
        end else if (advance) begin
            idx_q <= nxt[IDX_W-1:0];
            tag_q <= tag_q + TAG_W'(1);
        end
    end

    assign idx = idx_q;
    assign tag = tag_q;
endmodule

// File: rtl/vloop_ctrl.sv
module vloop_ctrl
    import vloop_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_valid,
    input  logic       has_pre,
    input  logic       stall,
    input  logic       pre_end,
    input  logic       body_end,
    input  logic       last,
    output logic       accept,
    output logic       issue,
    output logic       pre_fire,
    output logic       done,
    output seq_state_e state
);
    localparam int MAX_OUT = 1 << TAG_W;
    localparam int CNT_W   = TAG_W + 1;

    seq_state_e       st_q, st_d;
    logic             pre_wait_q;
    logic [CNT_W-1:0] outst_q;
    logic             cap_full, retire, issue_phase;

    assign cap_full    = (outst_q == CNT_W'(MAX_OUT));
    assign retire      = body_end && (outst_q != '0);
    assign accept      = (st_q == ST_IDLE) && start_valid;
    assign issue_phase = (st_q == ST_ISSUE) || ((st_q == ST_PRE) && !pre_wait_q);
    assign issue       = issue_phase && !stall && !cap_full;
    assign pre_fire    = (st_q == ST_PRE) && pre_wait_q && pre_end;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (accept) st_d = has_pre ? ST_PRE : ST_ISSUE;
            ST_PRE:   if (issue && last) st_d = ST_DRAIN;
            ST_ISSUE: if (issue && last) st_d = ST_DRAIN;
            ST_DRAIN: if (retire && outst_q == CNT_W'(1)) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            pre_wait_q <= 1'b0;
            outst_q    <= '0;
            done       <= 1'b0;
        end else begin
            st_q    <= st_d;
            done    <= (st_q == ST_DRAIN) && (st_d == ST_IDLE);
            outst_q <= outst_q + CNT_W'(issue) - CNT_W'(retire);
            if (accept)
                pre_wait_q <= 1'b0;
            else if (st_q == ST_PRE && issue)
                pre_wait_q <= 1'b1;
            else if (pre_fire)
                pre_wait_q <= 1'b0;
        end
    end

    assign state = st_q;
endmodule

// File: rtl/vloop_redirect.sv
module vloop_redirect #(
    parameter int PC_W  = 32,
    parameter int OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic [PC_W-1:0]  mark_pc,
    input  logic [OFF_W-1:0] mark_off,
    output logic             redirect_valid,
    output logic [PC_W-1:0]  redirect_pc
);
    logic [PC_W-1:0] back_bytes;
    assign back_bytes = PC_W'(mark_off) << 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
        end else begin
            redirect_valid <= fire;
            if (fire) redirect_pc <= mark_pc - back_bytes;
        end
    end
endmodule

// File: rtl/vloop_seq.sv
module vloop_seq
    import vloop_pkg::*;
#(
    parameter int IDX_W = 16,
    parameter int PC_W  = 32,
    parameter int OFF_W = 8,
    parameter int TAG_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_valid,
    input  logic [18:0]       start_word,
    input  logic [IDX_W-1:0]  trip_limit,
    input  logic              stall,
    input  logic              pre_end,
    input  logic [PC_W-1:0]   mark_pc,
    input  logic [OFF_W-1:0]  mark_off,
    input  logic              body_end,
    output logic              issue_valid,
    output logic [IDX_W-1:0]  issue_index,
    output logic [TAG_W-1:0]  issue_tag,
    output logic [2:0]        index_reg,
    output logic [63:0]       node_map,
    output logic              node_live_out,
    output logic              redirect_valid,
    output logic [PC_W-1:0]   redirect_pc,
    output logic              done
);
    loop_cfg_t         dec_cfg;
    logic [NODE_W-1:0] dec_map, map_q;
    logic              live_q;
    logic [2:0]        ireg_q;
    logic              accept, issue, pre_fire, last;
    seq_state_e        state;

    vloop_decode u_dec (
        .word     (start_word),
        .cfg      (dec_cfg),
        .node_map (dec_map)
    );

    vloop_ctrl #(.TAG_W(TAG_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_valid (start_valid),
        .has_pre     (dec_cfg.has_pre),
        .stall       (stall),
        .pre_end     (pre_end),
        .body_end    (body_end),
        .last        (last),
        .accept      (accept),
        .issue       (issue),
        .pre_fire    (pre_fire),
        .done        (done),
        .state       (state)
    );

    vloop_index #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_idx (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .step_log (dec_cfg.step_log),
        .limit    (trip_limit),
        .advance  (issue),
        .idx      (issue_index),
        .tag      (issue_tag),
        .last     (last)
    );

    // A redirect is only useful while iterations remain.
    vloop_redirect #(.PC_W(PC_W), .OFF_W(OFF_W)) u_redir (
        .clk            (clk),
        .rst            (rst),
        .fire           (pre_fire && (state == ST_PRE)),
        .mark_pc        (mark_pc),
        .mark_off       (mark_off),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            map_q  <= '0;
            live_q <= 1'b0;
            ireg_q <= '0;
        end else if (accept) begin
            map_q  <= dec_map;
            live_q <= dec_cfg.live_out;
            ireg_q <= dec_cfg.idx_reg;
        end
    end

    assign issue_valid   = issue;
    assign node_map      = map_q;
    assign node_live_out = live_q;
    assign index_reg     = ireg_q;
endmodule

// File: rtl/vloop_seq_chk.sv
module vloop_seq_chk #(
    parameter int IDX_W = 16,
    parameter int TAG_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             issue_valid,
    input logic [IDX_W-1:0] issue_index,
    input logic [TAG_W-1:0] issue_tag,
    input logic             body_end,
    input logic [63:0]      node_map,
    input logic             redirect_valid,
    input logic             done
);
    localparam int MAX_OUT = 1 << TAG_W;
    localparam int CNT_W   = TAG_W + 2;

    logic [CNT_W-1:0] inflight;

    always_ff @(posedge clk) begin
        if (rst) inflight <= '0;
        else inflight <= inflight + CNT_W'(issue_valid)
                         - CNT_W'(body_end && inflight != '0);
    end

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        inflight <= CNT_W'(MAX_OUT));

    assert_cap_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (inflight == CNT_W'(MAX_OUT)) |-> !issue_valid);

    assert_index_up_R3: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && $past(issue_valid)) |-> (issue_index > $past(issue_index)));

    assert_tag_step_R3: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && $past(issue_valid)) |-> (issue_tag == $past(issue_tag) + TAG_W'(1)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!issue_valid && inflight == '0));

    assert_redirect_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |=> !redirect_valid);

    assert_map_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && $past(issue_valid)) |-> $stable(node_map));
endmodule

bind vloop_seq vloop_seq_chk #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .issue_valid    (issue_valid),
    .issue_index    (issue_index),
    .issue_tag      (issue_tag),
    .body_end       (body_end),
    .node_map       (node_map),
    .redirect_valid (redirect_valid),
    .done           (done)
);

// File: tb/sim_vloop_seq.sv
`timescale 1ns/1ps
module sim_vloop_seq;
    localparam int IDX_W = 16;
    localparam int PC_W  = 32;
    localparam int OFF_W = 8;
    localparam int TAG_W = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_valid = 1'b0;
    logic [18:0]       start_word = '0;
    logic [IDX_W-1:0]  trip_limit = '0;
    logic              stall = 1'b0;
    logic              pre_end = 1'b0;
    logic [PC_W-1:0]   mark_pc = '0;
    logic [OFF_W-1:0]  mark_off = '0;
    logic              body_end = 1'b0;
    logic              issue_valid;
    logic [IDX_W-1:0]  issue_index;
    logic [TAG_W-1:0]  issue_tag;
    logic [2:0]        index_reg;
    logic [63:0]       node_map;
    logic              node_live_out;
    logic              redirect_valid;
    logic [PC_W-1:0]   redirect_pc;
    logic              done;

    always #2.5 clk = ~clk;

    vloop_seq #(.IDX_W(IDX_W), .PC_W(PC_W), .OFF_W(OFF_W), .TAG_W(TAG_W)) u0 (.*);

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int issued_cnt = 0;
    int first_cyc = 0;
    int last_cyc = 0;
    logic [IDX_W-1:0] exp_idx_q[$];
    logic [TAG_W-1:0] exp_tag_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever an iteration is released.
    always @(negedge clk) begin
        if (!rst && issue_valid) begin
            if (exp_idx_q.size() == 0) begin
                check(1'b0, "R4 unexpected iteration", 64'(issue_index), 64'hffff_ffff);
            end else begin
                logic [IDX_W-1:0] ei;
                logic [TAG_W-1:0] et;
                ei = exp_idx_q.pop_front();
                et = exp_tag_q.pop_front();
                check(issue_index == ei, "R3 index", 64'(issue_index), 64'(ei));
                check(issue_tag == et, "R3 tag", 64'(issue_tag), 64'(et));
            end
            if (issued_cnt == 0) first_cyc = cyc;
            last_cyc = cyc;
            issued_cnt++;
        end
    end

    function automatic logic [18:0] mk_word(input logic [2:0] ir, input logic [2:0] k,
        input logic [7:0] m, input logic [1:0] g, input logic fp, input logic lo, input logic pre);
        return {pre, lo, fp, g, m, k, ir};
    endfunction

    function automatic logic [63:0] exp_map(input logic [18:0] w);
        logic [63:0] r = '0;
        for (int j = 0; j < 8; j++)
            if (w[6+j]) r[32*w[16] + 8*w[15:14] + j] = 1'b1;
        r[w[2:0]] = 1'b1;
        return r;
    endfunction

    task automatic start(input logic [18:0] w, input logic [IDX_W-1:0] lim, output int cnt);
        int step;
        step = 1 << w[5:3];
        cnt  = int'(lim) / step + 1;
        for (int n = 0; n < cnt; n++) begin
            exp_idx_q.push_back(IDX_W'(n * step));
            exp_tag_q.push_back(TAG_W'(n));
        end
        issued_cnt = 0;
        @(posedge clk); #1;
        start_word = w; trip_limit = lim; start_valid = 1'b1;
        @(posedge clk); #1;
        start_valid = 1'b0;
    endtask

    task automatic wait_issued(input int n);
        while (issued_cnt < n) @(posedge clk);
    endtask

    task automatic retire(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1; body_end = 1'b1;
        end
        @(posedge clk); #1; body_end = 1'b0;
    endtask

    task automatic check_done(input string req);
        @(negedge clk);
        check(done == 1'b1, req, 64'(done), 64'd1);
        @(negedge clk);
        check(done == 1'b0, req, 64'(done), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog actual=hung expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int cnt;
        logic [18:0] w;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(issue_valid == 0 && done == 0 && redirect_valid == 0, "R1 reset outputs",
              {61'd0, issue_valid, done, redirect_valid}, 64'd0);
        check(node_map == 64'd0, "R1 reset map", node_map, 64'd0);
        #1 rst = 1'b0;
        repeat (2) @(negedge clk);
        check(issue_valid == 0 && issue_tag == 0, "R1 idle after reset", 64'(issue_valid), 64'd0);

        // R5: back-to-back, step 1, limit 4 -> 5 iterations
        w = mk_word(3'd5, 3'd0, 8'h0F, 2'd1, 1'b0, 1'b1, 1'b0);
        start(w, 16'd4, cnt);
        wait_issued(cnt);
        repeat (2) @(negedge clk);
        check(issued_cnt == 5, "R4 count limit4", 64'(issued_cnt), 64'd5);
        check(last_cyc - first_cyc == cnt - 1, "R5 consecutive", 64'(last_cyc - first_cyc), 64'(cnt - 1));
        check(node_map == exp_map(w), "R2 map int group1", node_map, exp_map(w));
        check(node_live_out == 1'b1 && index_reg == 3'd5, "R2 live-out and idx reg",
              {60'd0, node_live_out, index_reg}, {60'd0, 1'b1, 3'd5});
        retire(cnt);
        check_done("R9 done after last retire");

        // R3/R2: step 8, fp file group 2
        w = mk_word(3'd3, 3'd3, 8'hA5, 2'd2, 1'b1, 1'b0, 1'b0);
        start(w, 16'd20, cnt);
        wait_issued(cnt);
        repeat (2) @(negedge clk);
        check(issued_cnt == 3, "R3 step8 count", 64'(issued_cnt), 64'd3);
        check(node_map == exp_map(w), "R2 map fp group2", node_map, exp_map(w));
        check(node_live_out == 1'b0, "R2 live-in flag", 64'(node_live_out), 64'd0);
        retire(cnt);
        check_done("R9 done step8");
        check(node_map == exp_map(w), "R10 map held after done", node_map, exp_map(w));

        // R4: limit below step runs once
        w = mk_word(3'd0, 3'd7, 8'h00, 2'd0, 1'b0, 1'b0, 1'b0);
        start(w, 16'd0, cnt);
        wait_issued(1);
        repeat (3) @(negedge clk);
        check(issued_cnt == 1, "R4 single iteration", 64'(issued_cnt), 64'd1);
        retire(1);
        check_done("R9 done single");

        // R6: stall
        @(posedge clk); #1 stall = 1'b1;
        w = mk_word(3'd1, 3'd1, 8'h33, 2'd3, 1'b0, 1'b0, 1'b0);
        start(w, 16'd9, cnt);
        repeat (5) @(negedge clk);
        check(issued_cnt == 0 && issue_valid == 0, "R6 stalled", 64'(issued_cnt), 64'd0);
        @(posedge clk); #1 stall = 1'b0;
        wait_issued(2);
        @(posedge clk); #1 stall = 1'b1;
        repeat (3) @(negedge clk);
        check(issue_valid == 0, "R6 mid-loop stall", 64'(issue_valid), 64'd0);
        @(posedge clk); #1 stall = 1'b0;
        wait_issued(cnt);
        repeat (2) @(negedge clk);
        check(issued_cnt == 5, "R6 no skip", 64'(issued_cnt), 64'd5);
        retire(cnt);
        check_done("R9 done stall");

        // R7: cap of 16, plus R10 start ignored while busy
        w = mk_word(3'd2, 3'd0, 8'h81, 2'd0, 1'b1, 1'b1, 1'b0);
        start(w, 16'd19, cnt);
        repeat (30) @(negedge clk);
        check(issued_cnt == 16 && issue_valid == 0, "R7 cap reached", 64'(issued_cnt), 64'd16);
        @(posedge clk); #1;
        start_word = mk_word(3'd7, 3'd2, 8'hFF, 2'd1, 1'b0, 1'b0, 1'b1);
        start_valid = 1'b1;
        @(posedge clk); #1 start_valid = 1'b0;
        @(negedge clk);
        check(node_map == exp_map(w), "R10 start ignored while busy", node_map, exp_map(w));
        retire(1);
        repeat (3) @(negedge clk);
        check(issued_cnt == 17, "R7 one retire one issue", 64'(issued_cnt), 64'd17);
        retire(19);
        check_done("R9 done after cap");
        check(issued_cnt == 20, "R7 total", 64'(issued_cnt), 64'd20);

        // R11: all eight marked live-in, still back-to-back
        w = mk_word(3'd4, 3'd0, 8'hFF, 2'd0, 1'b0, 1'b0, 1'b0);
        start(w, 16'd5, cnt);
        wait_issued(cnt);
        repeat (2) @(negedge clk);
        check(last_cyc - first_cyc == cnt - 1, "R11 live-in timing", 64'(last_cyc - first_cyc), 64'(cnt - 1));
        retire(cnt);
        check_done("R11 done live-in");

        // R8: preamble mode, 3 iterations
        w = mk_word(3'd6, 3'd0, 8'h10, 2'd1, 1'b0, 1'b0, 1'b1);
        start(w, 16'd2, cnt);
        for (int k = 1; k < 3; k++) begin
            logic [PC_W-1:0] epc;
            wait_issued(k);
            @(negedge clk);
            check(issue_valid == 0, "R8 serial wait", 64'(issue_valid), 64'd0);
            @(negedge clk);
            check(issue_valid == 0, "R8 serial wait", 64'(issue_valid), 64'd0);
            @(posedge clk); #1;
            mark_pc = PC_W'(32'h1000 + k * 32'h40);
            mark_off = OFF_W'(5 + k);
            pre_end = 1'b1;
            epc = mark_pc - PC_W'((5 + k) * 4);
            @(posedge clk); #1 pre_end = 1'b0;
            @(negedge clk);
            check(redirect_valid == 1'b1, "R8 redirect pulse", 64'(redirect_valid), 64'd1);
            check(redirect_pc == epc, "R8 redirect target", 64'(redirect_pc), 64'(epc));
            check(issue_valid == 1'b1, "R8 next iteration", 64'(issue_valid), 64'd1);
        end
        wait_issued(3);
        @(posedge clk); #1 pre_end = 1'b1;
        @(posedge clk); #1 pre_end = 1'b0;
        @(negedge clk);
        check(redirect_valid == 1'b0 && issue_valid == 1'b0, "R8 last marker absorbed",
              {62'd0, redirect_valid, issue_valid}, 64'd0);
        retire(cnt);
        check_done("R9 done preamble");
        check(exp_idx_q.size() == 0, "R4 scoreboard empty", 64'(exp_idx_q.size()), 64'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule